// File: doc/BRIEF.md
# Half-Word to Byte Packing Buffer with Selectable Byte Order

This block sits between a 16-bit host data port and a byte-serial engine. It holds four byte lanes in a single storage word that both directions share. A host write pushes a half-word into the low two lanes, and everything already held moves up by two lanes. The engine drains transmit bytes one at a time, starting with the highest occupied lane. In the other direction the engine deposits received bytes one at a time into the next free lane. A host read returns the two lowest lanes as a half-word and then moves the remaining bytes down.

A `big_endian` input selects how the two bytes of a host half-word map onto the byte stream. The transmit side and the receive side each keep their own fill count. Sticky flags report a transmit underflow, a receive overrun and a read that found only one byte. A transmit-ready flag tells the host whether there is room for another half-word. Each cycle carries at most one operation, picked by a fixed priority.

Top module: `byte_pack_fifo`

## Requirements
- R1: After reset, both fill counts are 0, all four flags (`tx_ready`, `tx_underflow`, `rx_overrun`, `rx_single`) are 0, the stored word is zero, and `host_rdata` reads 0.
- R2: A host write is accepted only when `tx_count` is at most LANES-2 (2 by default). An accepted write moves the stored word up by two lanes, places the new half-word in lanes 1:0 and adds 2 to `tx_count`. A write attempted with a count of 3 or 4 changes no count, no byte and no flag.
- R3: Byte order of a written half-word {H,L} (H = bits 15:8, L = bits 7:0). With `big_endian`=0, L goes to lane 1 and H to lane 0. With `big_endian`=1, H goes to lane 1 and L to lane 0. The engine therefore sends L first in little-endian mode and H first in big-endian mode, and an older half-word goes out before a newer one.
- R4: `eng_tx_byte` always shows lane `tx_count`-1, or 0 when `tx_count` is 0. A take decrements a non-zero `tx_count`. A take at 0 leaves the count at 0 and sets `tx_underflow`. Every take sets `tx_ready`.
- R5: A push ORs `eng_rx_byte` into lane `rx_count` and increments `rx_count`. A push with `rx_count` equal to 4 drops the byte, leaves the count at 4 and sets `rx_overrun`.
- R6: `host_rdata` shows {lane1,lane0} when `big_endian`=0 and {lane0,lane1} when `big_endian`=1.
- R7: A host read with `rx_count`=1 sets `rx_single` and makes `rx_count` 0. With 2 or more bytes held, `rx_count` drops by 2, and with more than 2 held, the word also moves down by two lanes, with zeros filling lanes 3:2. A read with 0 bytes held changes no count.
- R8: Every host read clears `rx_overrun`. Every accepted host write clears `tx_underflow`. Apart from this, the flags stay set until reset.
- R9: An accepted host write that leaves `tx_count` above 2 clears `tx_ready`.
- R10: When several strobes are active in one cycle, only the highest-priority one acts, in the order host write, host read, engine take, engine push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | 1 = big-endian half-word byte order |
| host_wr | input | 1 | Host half-word write strobe |
| host_wdata | input | 16 | Host write half-word |
| host_rd | input | 1 | Host half-word read strobe |
| host_rdata | output | 16 | Half-word built from lanes 1:0 |
| eng_take | input | 1 | Engine takes one transmit byte |
| eng_tx_byte | output | 8 | Byte the next take delivers |
| eng_push | input | 1 | Engine delivers one received byte |
| eng_rx_byte | input | 8 | Received byte |
| tx_count | output | 3 | Transmit bytes held (0..4) |
| rx_count | output | 3 | Receive bytes held (0..4) |
| tx_ready | output | 1 | Room for another host write |
| tx_underflow | output | 1 | Sticky: take with nothing queued |
| rx_overrun | output | 1 | Sticky: push with all lanes full |
| rx_single | output | 1 | Sticky: read found only one byte |

## Verification
The bench builds the block with its defaults, 8-bit lanes and four lanes. With four lanes, every count value from 0 to 4 is reachable in a few operations, so the full/empty edges, the rejected write at 3 and 4, and reads at 0, 1, 2 and 3+ bytes all come up many times. A long run of operations, both single strobes and colliding strobes, with both byte orders, is compared every cycle with a lane-by-lane arithmetic model. Directed sequences fix literal byte orders and flag transitions.

// File: rtl/bpk_pkg.sv
package bpk_pkg;
   typedef enum logic [2:0] {
      OP_IDLE = 3'd0,
      OP_HWR  = 3'd1,
      OP_HRD  = 3'd2,
      OP_ETX  = 3'd3,
      OP_ERX  = 3'd4
   } bpk_op_e;
endpackage

// File: rtl/bpk_op_sel.sv
// Fixed-priority pick of one operation per cycle (R10).
module bpk_op_sel
   import bpk_pkg::*;
(
   input  logic    wr,
   input  logic    rd,
   input  logic    take,
   input  logic    push,
   output bpk_op_e op
);
   always_comb begin
      if (wr)        op = OP_HWR;
      else if (rd)   op = OP_HRD;
      else if (take) op = OP_ETX;
      else if (push) op = OP_ERX;
      else           op = OP_IDLE;
   end
endmodule

// File: rtl/bpk_half_swap.sv
// Optional exchange of the two byte lanes of a half-word.
module bpk_half_swap #(
   parameter int BYTE_W = 8
) (
   input  logic                swap,
   input  logic [2*BYTE_W-1:0] din,
   output logic [2*BYTE_W-1:0] dout
);
   for (genvar g = 0; g < 2; g++) begin : g_lane
      assign dout[g*BYTE_W +: BYTE_W] = swap ? din[(1-g)*BYTE_W +: BYTE_W]
                                             : din[g*BYTE_W +: BYTE_W];
   end
endmodule

// File: rtl/bpk_store.sv
// Shared lane word, both fill counts and the sticky flags.
module bpk_store
   import bpk_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4,
   localparam int W  = BYTE_W * LANES,
   localparam int HW = 2 * BYTE_W,
   localparam int CW = $clog2(LANES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bpk_op_e           op,
   input  logic [HW-1:0]     wr_half,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic [HW-1:0]     lo_half,
   output logic [BYTE_W-1:0] tx_byte,
   output logic [CW-1:0]     tx_cnt,
   output logic [CW-1:0]     rx_cnt,
   output logic              tx_rdy,
   output logic              tx_udf,
   output logic              rx_ovr,
   output logic              rx_one
);
   logic [W-1:0]  word_q, word_d;
   logic [CW-1:0] txc_q, txc_d, rxc_q, rxc_d;
   logic          rdy_q, rdy_d, udf_q, udf_d, ovr_q, ovr_d, one_q, one_d;

   always_comb begin
      tx_byte = '0;
      for (int i = 0; i < LANES; i++) begin
         if (txc_q == CW'(i + 1)) tx_byte = word_q[i*BYTE_W +: BYTE_W];
      end
   end

   always_comb begin
      word_d = word_q;
      txc_d  = txc_q;
      rxc_d  = rxc_q;
      rdy_d  = rdy_q;
      udf_d  = udf_q;
      ovr_d  = ovr_q;
      one_d  = one_q;
      unique case (op)
         OP_HWR: begin
            if (txc_q <= CW'(LANES - 2)) begin
               word_d = {word_q[W-HW-1:0], wr_half};
               txc_d  = txc_q + CW'(2);
               udf_d  = 1'b0;
               if (txc_d > CW'(2)) rdy_d = 1'b0;
            end
         end
         OP_HRD: begin
            ovr_d = 1'b0;
            if (rxc_q == CW'(1)) begin
               one_d = 1'b1;
               rxc_d = '0;
            end else if (rxc_q > CW'(1)) begin
               if (rxc_q > CW'(2)) word_d = {{HW{1'b0}}, word_q[W-1:HW]};
               rxc_d = rxc_q - CW'(2);
            end
         end
         OP_ETX: begin
            rdy_d = 1'b1;
            if (txc_q == '0) udf_d = 1'b1;
            else             txc_d = txc_q - CW'(1);
         end
         OP_ERX: begin
            if (rxc_q == CW'(LANES)) begin
               ovr_d = 1'b1;
            end else begin
               for (int i = 0; i < LANES; i++) begin
                  if (rxc_q == CW'(i))
                     word_d[i*BYTE_W +: BYTE_W] = word_q[i*BYTE_W +: BYTE_W] | rx_byte;
               end
               rxc_d = rxc_q + CW'(1);
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         txc_q  <= '0;
         rxc_q  <= '0;
         rdy_q  <= 1'b0;
         udf_q  <= 1'b0;
         ovr_q  <= 1'b0;
         one_q  <= 1'b0;
      end else begin
         word_q <= word_d;
         txc_q  <= txc_d;
         rxc_q  <= rxc_d;
         rdy_q  <= rdy_d;
         udf_q  <= udf_d;
         ovr_q  <= ovr_d;
         one_q  <= one_d;
      end
   end

   assign lo_half = word_q[HW-1:0];
   assign tx_cnt  = txc_q;
   assign rx_cnt  = rxc_q;
   assign tx_rdy  = rdy_q;
   assign tx_udf  = udf_q;
   assign rx_ovr  = ovr_q;
   assign rx_one  = one_q;
endmodule

// File: rtl/byte_pack_fifo.sv
module byte_pack_fifo
   import bpk_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4,
   localparam int HW = 2 * BYTE_W,
   localparam int CW = $clog2(LANES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              big_endian,
   input  logic              host_wr,
   input  logic [HW-1:0]     host_wdata,
   input  logic              host_rd,
   output logic [HW-1:0]     host_rdata,
   input  logic              eng_take,
   output logic [BYTE_W-1:0] eng_tx_byte,
   input  logic              eng_push,
   input  logic [BYTE_W-1:0] eng_rx_byte,
   output logic [CW-1:0]     tx_count,
   output logic [CW-1:0]     rx_count,
   output logic              tx_ready,
   output logic              tx_underflow,
   output logic              rx_overrun,
   output logic              rx_single
);
   if (LANES < 4 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("byte_pack_fifo: LANES must be even and at least 4");
   end
   if (BYTE_W < 1) begin : g_bad_width
      $error("byte_pack_fifo: BYTE_W must be positive");
   end

   bpk_op_e       op;
   logic [HW-1:0] wr_placed, lo_half;

   bpk_op_sel u_sel (
      .wr   (host_wr),
      .rd   (host_rd),
      .take (eng_take),
      .push (eng_push),
      .op   (op)
   );

   // Little-endian places the low byte in the upper lane of the pair.
   bpk_half_swap #(.BYTE_W(BYTE_W)) u_wr_swap (
      .swap (~big_endian),
      .din  (host_wdata),
      .dout (wr_placed)
   );

   bpk_half_swap #(.BYTE_W(BYTE_W)) u_rd_swap (
      .swap (big_endian),
      .din  (lo_half),
      .dout (host_rdata)
   );

   bpk_store #(.BYTE_W(BYTE_W), .LANES(LANES)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .wr_half (wr_placed),
      .rx_byte (eng_rx_byte),
      .lo_half (lo_half),
      .tx_byte (eng_tx_byte),
      .tx_cnt  (tx_count),
      .rx_cnt  (rx_count),
      .tx_rdy  (tx_ready),
      .tx_udf  (tx_underflow),
      .rx_ovr  (rx_overrun),
      .rx_one  (rx_single)
   );
endmodule

// File: rtl/byte_pack_fifo_chk.sv
module byte_pack_fifo_chk #(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4,
   localparam int CW = $clog2(LANES + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_wr,
   input logic          host_rd,
   input logic          eng_take,
   input logic          eng_push,
   input logic [CW-1:0] tx_count,
   input logic [CW-1:0] rx_count,
   input logic          tx_ready,
   input logic          tx_underflow,
   input logic          rx_overrun,
   input logic          rx_single
);
   localparam int LANE_BITS = BYTE_W * LANES;

   assert_counts_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(tx_count) <= LANES) && (int'(rx_count) <= LANES) && (LANE_BITS > 0));

   assert_write_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && int'(tx_count) <= LANES - 2)
      |=> (int'(tx_count) == int'($past(tx_count)) + 2) && !tx_underflow);

   assert_write_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && int'(tx_count) > LANES - 2)
      |=> $stable(tx_count) && $stable(rx_count) && $stable(tx_ready));

   assert_take_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_take && !host_wr && !host_rd && tx_count == '0)
      |=> tx_underflow && tx_count == '0 && tx_ready);

   assert_push_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_push && !host_wr && !host_rd && !eng_take && int'(rx_count) == LANES)
      |=> rx_overrun && $stable(rx_count));

   assert_single_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !host_wr && rx_count == CW'(1))
      |=> rx_single && rx_count == '0);

   assert_read_clears_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !host_wr) |=> !rx_overrun);

   assert_write_drops_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && int'(tx_count) <= LANES - 2 && int'(tx_count) > 0) |=> !tx_ready);

   assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr |=> $stable(rx_count));
endmodule

bind byte_pack_fifo byte_pack_fifo_chk #(.BYTE_W(BYTE_W), .LANES(LANES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .host_wr      (host_wr),
   .host_rd      (host_rd),
   .eng_take     (eng_take),
   .eng_push     (eng_push),
   .tx_count     (tx_count),
   .rx_count     (rx_count),
   .tx_ready     (tx_ready),
   .tx_underflow (tx_underflow),
   .rx_overrun   (rx_overrun),
   .rx_single    (rx_single)
);

// File: tb/tb_byte_pack_fifo.sv
`timescale 1ns/1ps
module tb_byte_pack_fifo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        big_endian = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0, eng_take = 1'b0, eng_push = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic [7:0]  eng_tx_byte;
   logic [7:0]  eng_rx_byte = '0;
   logic [2:0]  tx_count, rx_count;
   logic        tx_ready, tx_underflow, rx_overrun, rx_single;

   int checks = 0;
   int fails  = 0;

   logic [7:0] m [4];
   int  mtx, mrx;
   bit  mrdy, mudf, movr, mone;

   always #2.5 clk = ~clk;

   byte_pack_fifo dut (
      .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
      .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rd(host_rd), .host_rdata(host_rdata),
      .eng_take(eng_take), .eng_tx_byte(eng_tx_byte),
      .eng_push(eng_push), .eng_rx_byte(eng_rx_byte),
      .tx_count(tx_count), .rx_count(rx_count),
      .tx_ready(tx_ready), .tx_underflow(tx_underflow),
      .rx_overrun(rx_overrun), .rx_single(rx_single)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < 4; i++) m[i] = 8'h00;
      mtx = 0; mrx = 0; mrdy = 0; mudf = 0; movr = 0; mone = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      host_wr = 0; host_rd = 0; eng_take = 0; eng_push = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_clear();
   endtask

   task automatic check_regs();
      chk("R2/R4 tx_count", int'(tx_count), mtx);
      chk("R5/R7 rx_count", int'(rx_count), mrx);
      chk("R9 tx_ready", int'(tx_ready), int'(mrdy));
      chk("R4/R8 tx_underflow", int'(tx_underflow), int'(mudf));
      chk("R5/R8 rx_overrun", int'(rx_overrun), int'(movr));
      chk("R7 rx_single", int'(rx_single), int'(mone));
   endtask

   // Apply one cycle of strobes, compare combinational views before the edge
   // and registered state after it.
   task automatic do_op(input bit wr, input bit rd, input bit tk, input bit ps,
                        input bit be, input logic [15:0] wd, input logic [7:0] rb);
      logic [7:0]  eb;
      logic [15:0] er;
      @(negedge clk);
      host_wr = wr; host_rd = rd; eng_take = tk; eng_push = ps;
      big_endian = be; host_wdata = wd; eng_rx_byte = rb;
      #1;
      eb = (mtx == 0) ? 8'h00 : m[mtx-1];
      chk(mtx == 0 ? "R4 tx_byte at empty" : "R3 tx_byte", int'(eng_tx_byte), int'(eb));
      er = be ? {m[0], m[1]} : {m[1], m[0]};
      chk("R6 host_rdata", int'(host_rdata), int'(er));
      @(posedge clk);
      if (wr) begin
         if (mtx <= 2) begin
            m[3] = m[1]; m[2] = m[0];
            m[1] = be ? wd[15:8] : wd[7:0];
            m[0] = be ? wd[7:0]  : wd[15:8];
            mtx += 2; mudf = 0;
            if (mtx > 2) mrdy = 0;
         end
      end else if (rd) begin
         movr = 0;
         if (mrx == 1) begin
            mone = 1; mrx = 0;
         end else if (mrx >= 2) begin
            if (mrx > 2) begin
               m[0] = m[2]; m[1] = m[3]; m[2] = 8'h00; m[3] = 8'h00;
            end
            mrx -= 2;
         end
      end else if (tk) begin
         mrdy = 1;
         if (mtx == 0) mudf = 1;
         else mtx--;
      end else if (ps) begin
         if (mrx == 4) movr = 1;
         else begin
            m[mrx] = m[mrx] | rb;
            mrx++;
         end
      end
      #1;
      check_regs();
   endtask

   task automatic idle();
      @(negedge clk);
      host_wr = 0; host_rd = 0; eng_take = 0; eng_push = 0;
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      model_clear();
      do_reset();
      #1;
      // R1 reset state
      check_regs();
      chk("R1 host_rdata", int'(host_rdata), 0);
      chk("R1 tx_count", int'(tx_count), 0);

      // R3 little-endian: low byte leaves first
      do_op(1,0,0,0, 0, 16'hA1B2, 8'h00);
      chk("R3 LE first byte", int'(eng_tx_byte), 'hB2);
      do_op(0,0,1,0, 0, 16'h0, 8'h00);
      chk("R3 LE second byte", int'(eng_tx_byte), 'hA1);
      chk("R4 tx_ready after take", int'(tx_ready), 1);
      do_op(0,0,1,0, 0, 16'h0, 8'h00);

      // R3 big-endian: high byte leaves first
      do_reset();
      do_op(1,0,0,0, 1, 16'hA1B2, 8'h00);
      chk("R3 BE first byte", int'(eng_tx_byte), 'hA1);
      do_op(0,0,1,0, 1, 16'h0, 8'h00);
      chk("R3 BE second byte", int'(eng_tx_byte), 'hB2);

      // R2/R9/R4/R8: fill, reject, drain, underflow, recovery
      do_reset();
      do_op(0,0,1,0, 0, 16'h0, 8'h00);      // underflow at empty, ready set
      chk("R4 underflow flag", int'(tx_underflow), 1);
      do_op(1,0,0,0, 0, 16'h1122, 8'h00);
      chk("R8 write clears underflow", int'(tx_underflow), 0);
      chk("R9 ready kept at count 2", int'(tx_ready), 1);
      do_op(1,0,0,0, 0, 16'h3344, 8'h00);
      chk("R9 ready cleared at count 4", int'(tx_ready), 0);
      do_op(1,0,0,0, 0, 16'h5566, 8'h00);
      chk("R2 reject at count 4", int'(tx_count), 4);
      do_op(0,0,1,0, 0, 16'h0, 8'h00);
      do_op(1,0,0,0, 0, 16'h7788, 8'h00);
      chk("R2 reject at count 3", int'(tx_count), 3);
      chk("R2 reject keeps byte", int'(eng_tx_byte), 'h11);
      for (int i = 0; i < 4; i++) do_op(0,0,1,0, 0, 16'h0, 8'h00);
      chk("R4 drained underflow", int'(tx_underflow), 1);

      // R5/R6/R7/R8 receive path
      do_reset();
      for (int i = 1; i <= 5; i++) do_op(0,0,0,1, 0, 16'h0, 8'(i));
      chk("R5 overrun at full", int'(rx_overrun), 1);
      chk("R5 count held at 4", int'(rx_count), 4);
      chk("R6 LE read data", int'(host_rdata), 'h0201);
      do_op(0,1,0,0, 0, 16'h0, 8'h00);
      chk("R8 read clears overrun", int'(rx_overrun), 0);
      chk("R7 shifted lanes", int'(host_rdata), 'h0403);
      do_op(0,1,0,0, 0, 16'h0, 8'h00);
      chk("R7 count 0 after two reads", int'(rx_count), 0);
      do_op(0,1,0,0, 0, 16'h0, 8'h00);
      chk("R7 empty read no single", int'(rx_single), 0);

      do_reset();
      do_op(0,0,0,1, 1, 16'h0, 8'h5A);
      do_op(0,0,0,1, 1, 16'h0, 8'hC3);
      chk("R6 BE read data", int'(host_rdata), 'h5AC3);

      do_reset();
      do_op(0,0,0,1, 0, 16'h0, 8'h77);
      do_op(0,1,0,0, 0, 16'h0, 8'h00);
      chk("R7 single flag", int'(rx_single), 1);
      chk("R7 single empties", int'(rx_count), 0);

      // R10 priority
      do_reset();
      do_op(0,0,0,1, 0, 16'h0, 8'h10);
      do_op(1,1,1,1, 0, 16'hBEEF, 8'h20);
      chk("R10 write wins tx", int'(tx_count), 2);
      chk("R10 write wins rx", int'(rx_count), 1);
      do_op(0,1,1,1, 0, 16'h0, 8'h30);
      chk("R10 read beats take", int'(tx_count), 2);
      chk("R10 read acted", int'(rx_single), 1);
      do_op(0,0,1,1, 0, 16'h0, 8'h40);
      chk("R10 take beats push", int'(rx_count), 0);

      // Long mixed sweep against the lane model
      do_reset();
      for (int n = 0; n < 6000; n++) begin
         int sel;
         bit wr, rd, tk, ps;
         sel = int'($urandom_range(0, 19));
         wr = (sel < 4) || (sel == 16);
         rd = (sel >= 4 && sel < 8) || (sel == 16) || (sel == 17);
         tk = (sel >= 8 && sel < 12) || (sel == 17) || (sel == 18);
         ps = (sel >= 12 && sel < 16) || (sel == 18) || (sel == 19);
         do_op(wr, rd, tk, ps, 1'($urandom_range(0, 1)),
               16'($urandom), 8'($urandom));
         if (n % 1500 == 1499) do_reset();
      end
      idle();

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule